// File: doc/BRIEF.md
# I/O SMI State Capture Unit

This unit follows the retirement stream of a core and keeps a candidate record of the last I/O instruction that finished. It also keeps a candidate record of the last iteration of a repeated string I/O instruction that finished. Any other instruction that retires drops the candidate. When a system management interrupt is taken, the unit freezes the candidate into a 32-bit state word and a 32-bit memory-address word. The save logic copies these two words into the state save area. The handler reads them and judges whether the interrupt was probably caused by the I/O access it interrupted.

A set flag in the state word says that the interrupt landed right after a finished I/O operation. The flag does not prove the interrupt was synchronous: an unrelated interrupt that arrives at that moment sets it too. The flag qualifies every other field. When the flag is clear, the unit drives every other field to zero.

All pins are plain strobes and levels; there is no back-pressure. The core presents at most one retirement event per cycle. The captured words are held registers that change only on an interrupt-taken strobe, so the consumer may sample them at any later time.

Top module: `iosmi_state_capture`

## Requirements
- R1: After reset, save_state and save_maddr are both zero.
- R2: An SMI taken in the cycle after a legal I/O retire, with no other retirement in between, sets save_state bit 0 and captures that operation's port, length and kind.
- R3: A legal REP-iteration strobe makes a candidate in the same way. A REP-iteration strobe is legal when its kind is REP OUTS 0110 or REP INS 0111 and its length is legal. An SMI that follows it sets the flag.
- R4: A non-I/O retirement between the I/O event and the SMI leaves save_state bit 0 clear.
- R5: Whenever save_state bit 0 is clear, the rest of save_state and all of save_maddr are zero. This includes an SMI with no I/O since reset and a second SMI with no I/O after the first.
- R6: save_state is laid out as follows: flag in bit 0, length in bits 3:1, kind in bits 7:4, zero in bits 15:8, port in bits 31:16.
- R7: The length codes are 001 for a byte, 010 for a word and 100 for a dword. An I/O event with any other length code counts as a non-I/O retirement.
- R8: The kind codes are as follows. IN with an immediate port is 1001 and IN through DX is 0001. OUT with an immediate port is 1000 and OUT through DX is 0000. INS is 0011 and OUTS is 0010. REP INS is 0111 and REP OUTS is 0110. Any other kind on io_retire counts as a non-I/O retirement.
- R9: For string kinds (kind bit 1 set), save_maddr holds the operation's 32-bit memory address. For the other valid kinds, save_maddr is zero.
- R10: save_state and save_maddr change only in the cycle after smi_taken; I/O and other retirements alone never alter them.
- R11: An SMI in the same cycle as an I/O retire captures the candidate from before that cycle. The new retire becomes the candidate for a later SMI.
- R12: When several I/O events retire before an SMI, the most recent one is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_retire | input | 1 | An I/O instruction retired successfully this cycle |
| rep_step | input | 1 | One iteration of a REP string I/O instruction completed this cycle |
| other_retire | input | 1 | A non-I/O instruction retired this cycle |
| smi_taken | input | 1 | A system management interrupt is taken this cycle |
| io_port | input | 16 | Port address of the I/O event |
| io_len | input | 3 | Access length code of the I/O event |
| io_kind | input | 4 | Instruction kind code of the I/O event |
| io_maddr | input | 32 | Memory address of a string I/O event |
| save_state | output | 32 | Packed I/O state word frozen at the last SMI |
| save_maddr | output | 32 | Memory address word frozen at the last SMI |

## Verification
A stale or wrongly cleared candidate shows up only at the next SMI. It shows up one cycle after that SMI, as a flag or field that disagrees with the retirement history. The bench therefore puts an SMI after each distinct history. A wrong load or clear priority between strobes in the same cycle shows up only when the following SMI captures the wrong record, so the bench includes those collisions. Any write to the outputs outside an SMI would corrupt the held words at once. Each bench check of those words catches it within one cycle.

// File: rtl/iosmi_pkg.sv
package iosmi_pkg;
  localparam int PORT_W   = 16;
  localparam int LEN_W    = 3;
  localparam int KIND_W   = 4;
  localparam int ADDR_W   = 32;
  localparam int WORD_W   = 32;
  localparam int FLAG_BIT = 0;
  localparam int LEN_LSB  = 1;
  localparam int KIND_LSB = LEN_LSB + LEN_W;
  localparam int RSVD_LSB = KIND_LSB + KIND_W;
  localparam int PORT_LSB = WORD_W - PORT_W;
  localparam int STR_BIT  = 1;

  typedef enum logic [KIND_W-1:0] {
    K_OUT_DX   = 4'b0000,
    K_IN_DX    = 4'b0001,
    K_OUTS     = 4'b0010,
    K_INS      = 4'b0011,
    K_REP_OUTS = 4'b0110,
    K_REP_INS  = 4'b0111,
    K_OUT_IMM  = 4'b1000,
    K_IN_IMM   = 4'b1001
  } kind_e;

  typedef struct packed {
    logic              vld;
    logic [PORT_W-1:0] port;
    logic [LEN_W-1:0]  len;
    logic [KIND_W-1:0] kind;
    logic [ADDR_W-1:0] maddr;
  } cand_t;

  function automatic logic len_ok(input logic [LEN_W-1:0] l);
    return (l == 3'b001) || (l == 3'b010) || (l == 3'b100);
  endfunction

  function automatic logic kind_ok(input logic [KIND_W-1:0] k);
    case (k)
      K_OUT_DX, K_IN_DX, K_OUTS, K_INS,
      K_REP_OUTS, K_REP_INS, K_OUT_IMM, K_IN_IMM: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic kind_rep(input logic [KIND_W-1:0] k);
    return (k == K_REP_OUTS) || (k == K_REP_INS);
  endfunction

  function automatic logic kind_str(input logic [KIND_W-1:0] k);
    return k[STR_BIT];
  endfunction
endpackage

// File: rtl/iosmi_classify.sv
module iosmi_classify
  import iosmi_pkg::*;
(
  input  logic              io_retire,
  input  logic              rep_step,
  input  logic              other_retire,
  input  logic [LEN_W-1:0]  io_len,
  input  logic [KIND_W-1:0] io_kind,
  output logic              ev_load,
  output logic              ev_drop
);
  logic io_good;
  logic rep_good;

  always_comb begin
    io_good  = io_retire && len_ok(io_len) && kind_ok(io_kind);
    rep_good = rep_step && len_ok(io_len) && kind_rep(io_kind);
    ev_load  = io_good || rep_good;
    ev_drop  = other_retire || ((io_retire || rep_step) && !ev_load);
  end
endmodule

// File: rtl/iosmi_tracker.sv
module iosmi_tracker
  import iosmi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic              ev_drop,
  input  logic              smi_taken,
  input  logic [PORT_W-1:0] io_port,
  input  logic [LEN_W-1:0]  io_len,
  input  logic [KIND_W-1:0] io_kind,
  input  logic [ADDR_W-1:0] io_maddr,
  output cand_t             cand
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand <= '0;
    end else if (ev_load) begin
      cand.vld   <= 1'b1;
      cand.port  <= io_port;
      cand.len   <= io_len;
      cand.kind  <= io_kind;
      cand.maddr <= kind_str(io_kind) ? io_maddr : '0;
    end else if (ev_drop || smi_taken) begin
      cand <= '0;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && smi_taken) |=> cand.vld); // R11
endmodule

// File: rtl/iosmi_capture.sv
module iosmi_capture
  import iosmi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smi_taken,
  input  cand_t             cand,
  output logic [WORD_W-1:0] state_q,
  output logic [ADDR_W-1:0] maddr_q
);
  logic [WORD_W-1:0] packed_w;

  always_comb begin
    packed_w = '0;
    packed_w[FLAG_BIT]                  = 1'b1;
    packed_w[LEN_LSB  +: LEN_W]         = cand.len;
    packed_w[KIND_LSB +: KIND_W]        = cand.kind;
    packed_w[RSVD_LSB +: (PORT_LSB-RSVD_LSB)] = '0;
    packed_w[PORT_LSB +: PORT_W]        = cand.port;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      maddr_q <= '0;
    end else if (smi_taken) begin
      state_q <= cand.vld ? packed_w : '0;
      maddr_q <= cand.vld ? cand.maddr : '0;
    end
  end

  AST_FLAG_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !state_q[FLAG_BIT] |-> (state_q == '0 && maddr_q == '0)); // R5
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !smi_taken |=> ($stable(state_q) && $stable(maddr_q))); // R10
  AST_LEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q[FLAG_BIT] |-> ($countones(state_q[LEN_LSB +: LEN_W]) == 1)); // R7
endmodule

// File: rtl/iosmi_state_capture.sv
module iosmi_state_capture
  import iosmi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_retire,
  input  logic        rep_step,
  input  logic        other_retire,
  input  logic        smi_taken,
  input  logic [15:0] io_port,
  input  logic [2:0]  io_len,
  input  logic [3:0]  io_kind,
  input  logic [31:0] io_maddr,
  output logic [31:0] save_state,
  output logic [31:0] save_maddr
);
  logic  ev_load;
  logic  ev_drop;
  cand_t cand;

  iosmi_classify u_classify (
    .io_retire    (io_retire),
    .rep_step     (rep_step),
    .other_retire (other_retire),
    .io_len       (io_len),
    .io_kind      (io_kind),
    .ev_load      (ev_load),
    .ev_drop      (ev_drop)
  );

  iosmi_tracker u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_load   (ev_load),
    .ev_drop   (ev_drop),
    .smi_taken (smi_taken),
    .io_port   (io_port),
    .io_len    (io_len),
    .io_kind   (io_kind),
    .io_maddr  (io_maddr),
    .cand      (cand)
  );

  iosmi_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .smi_taken (smi_taken),
    .cand      (cand),
    .state_q   (save_state),
    .maddr_q   (save_maddr)
  );

  AST_SYNC_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (io_retire && !other_retire && len_ok(io_len) && kind_ok(io_kind))
    ##1 (smi_taken && !other_retire) |=> save_state[FLAG_BIT]); // R2
  AST_OTHER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (other_retire && !io_retire && !rep_step) ##1 (smi_taken && !io_retire && !rep_step)
    |=> !save_state[FLAG_BIT]); // R4
  AST_NONSTR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (save_state[FLAG_BIT] && !save_state[KIND_LSB+STR_BIT]) |-> save_maddr == '0); // R9
endmodule

// File: tb/iosmi_state_capture_tb_top.sv
module iosmi_state_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_retire = 1'b0, rep_step = 1'b0, other_retire = 1'b0, smi_taken = 1'b0;
  logic [15:0] io_port = '0;
  logic [2:0]  io_len = '0;
  logic [3:0]  io_kind = '0;
  logic [31:0] io_maddr = '0;
  logic [31:0] save_state, save_maddr;

  int checks = 0;
  int errors = 0;
  logic smi_d = 1'b0;

  logic [31:0] exp_w[$];
  logic [31:0] exp_a[$];
  string       exp_t[$];

  // reference candidate
  logic        m_vld = 1'b0;
  logic [31:0] m_word = '0;
  logic [31:0] m_addr = '0;

  always #2 clk = ~clk;

  iosmi_state_capture dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic m_len_ok(input logic [2:0] l);
    return l == 3'b001 || l == 3'b010 || l == 3'b100;
  endfunction
  function automatic logic m_kind_ok(input logic [3:0] k);
    return k inside {4'b1001, 4'b0001, 4'b1000, 4'b0000, 4'b0011, 4'b0010, 4'b0111, 4'b0110};
  endfunction

  // model update for one event; rep=1 means REP iteration strobe
  task automatic m_event(input logic rep, input logic [15:0] p, input logic [2:0] l,
                         input logic [3:0] k, input logic [31:0] a);
    logic ok;
    ok = m_len_ok(l) && (rep ? (k == 4'b0111 || k == 4'b0110) : m_kind_ok(k));
    if (ok) begin
      m_vld  = 1'b1;
      m_word = {p, 8'h00, k, l, 1'b1};
      m_addr = k[1] ? a : 32'h0;
    end else begin
      m_vld = 1'b0; m_word = '0; m_addr = '0;
    end
  endtask

  task automatic io_ev(input logic rep, input logic [15:0] p, input logic [2:0] l,
                       input logic [3:0] k, input logic [31:0] a, input logic with_smi,
                       input string tag);
    @(negedge clk);
    io_retire = !rep; rep_step = rep;
    io_port = p; io_len = l; io_kind = k; io_maddr = a;
    smi_taken = with_smi;
    if (with_smi) begin
      exp_w.push_back(m_vld ? m_word : 32'h0);
      exp_a.push_back(m_vld ? m_addr : 32'h0);
      exp_t.push_back(tag);
    end
    m_event(rep, p, l, k, a);
    @(negedge clk);
    io_retire = 0; rep_step = 0; smi_taken = 0;
  endtask

  task automatic other_ev();
    @(negedge clk);
    other_retire = 1;
    m_vld = 0; m_word = '0; m_addr = '0;
    @(negedge clk);
    other_retire = 0;
  endtask

  task automatic smi(input string tag);
    @(negedge clk);
    smi_taken = 1;
    exp_w.push_back(m_vld ? m_word : 32'h0);
    exp_a.push_back(m_vld ? m_addr : 32'h0);
    exp_t.push_back(tag);
    m_vld = 0; m_word = '0; m_addr = '0;
    @(negedge clk);
    smi_taken = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) smi_d <= smi_taken;

  always @(negedge clk) begin
    if (smi_d && exp_w.size() > 0) begin
      string t;
      logic [31:0] w, a;
      w = exp_w.pop_front(); a = exp_a.pop_front(); t = exp_t.pop_front();
      check({t, " state"}, save_state, w);
      check({t, " maddr"}, save_maddr, a);
    end
  end

  initial begin
    logic [31:0] held_w, held_a;
    repeat (3) @(negedge clk);
    check("R1 reset state", save_state, 32'h0);
    check("R1 reset maddr", save_maddr, 32'h0);
    rst_n = 1;
    @(negedge clk);

    smi("R5 no io");
    io_ev(0, 16'h0060, 3'b001, 4'b1001, 32'h0, 0, "");
    smi("R2 in imm byte");
    smi("R5 second smi");
    io_ev(0, 16'hCF8, 3'b100, 4'b0000, 32'h0, 0, "");
    smi("R6 out dx dword");
    io_ev(0, 16'h03F8, 3'b010, 4'b0011, 32'h0010_2000, 0, "");
    smi("R9 ins addr");
    io_ev(0, 16'h0080, 3'b001, 4'b1000, 32'hDEAD_BEEF, 0, "");
    smi("R9 nonstring addr zero");
    io_ev(1, 16'h01F0, 3'b010, 4'b0111, 32'h0000_8000, 0, "");
    smi("R3 rep ins");
    io_ev(1, 16'h01F0, 3'b010, 4'b0010, 32'h0000_8000, 0, "");
    smi("R3 rep bad kind");
    io_ev(0, 16'h0070, 3'b001, 4'b0001, 32'h0, 0, "");
    other_ev();
    smi("R4 other between");
    io_ev(0, 16'h0070, 3'b011, 4'b0001, 32'h0, 0, "");
    smi("R7 bad len");
    io_ev(0, 16'h0070, 3'b001, 4'b0100, 32'h0, 0, "");
    smi("R8 bad kind");
    io_ev(0, 16'h0071, 3'b001, 4'b0001, 32'h0, 0, "");
    io_ev(0, 16'h0C00, 3'b010, 4'b0110, 32'h00AB_CDEF, 0, "");
    smi("R12 latest wins");
    io_ev(0, 16'h0064, 3'b001, 4'b1001, 32'h0, 0, "");
    io_ev(0, 16'h0092, 3'b100, 4'b0010, 32'h1234_5678, 1, "R11 same cycle");
    smi("R11 later smi");
    // R10: retirements without SMI leave outputs alone
    held_w = save_state; held_a = save_maddr;
    io_ev(0, 16'h0040, 3'b001, 4'b1000, 32'h0, 0, "");
    other_ev();
    check("R10 hold state", save_state, held_w);
    check("R10 hold maddr", save_maddr, held_a);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule